// File: doc/BRIEF.md
# Word FIFO Pair with Flush

This block sits between a register bus and a byte-serial engine. It buffers outgoing data in a transmit queue of 32-bit words and incoming data in a receive queue of 32-bit words. Software pushes transmit words by writing one data address and pops receive words by reading another. The serial side takes transmit bytes one at a time, least significant byte first. It hands receive bytes in the same order, and the block packs every four of them into a word.

A control word holds two trigger thresholds and two flush requests. A flush request bit stays readable as 1 until the flush has actually emptied its queue, then returns to 0 by itself. A status word reports transmit free slots and receive filled slots in two separate nibbles. Two level outputs request service: one when enough transmit space is free, one when enough receive words are waiting.

The serial engine marks the last byte of a message with a last flag. On transmit, that flag retires the current word early. On receive, it closes a partial word with its upper bytes zero. Writing a full transmit queue and reading an empty receive queue are both reported by one-cycle flags.

Top module: `word_fifo_pair`

## Requirements
- R1: After reset both queues are empty, status reads 0x80, control reads 0, `tx_req` is 1, `rx_req` is 0, `ser_tx_valid` is 0 and `ser_rx_ready` is 1.
- R2: Transmit words leave on the serial side in write order, each word as bytes [7:0], [15:8], [23:16], [31:24].
- R3: A transmit byte taken with `ser_tx_last` set retires its word, and the next byte offered is bits [7:0] of the following word.
- R4: Received bytes are packed little-endian: four bytes form one word, the first in bits [7:0]. A byte with `ser_rx_last` set closes the word early with the unfilled upper bytes reading 0. Receive words are read back in arrival order.
- R5: Status (address 1) bits [7:4] hold the number of free transmit slots (0 to 8), and bits [3:0] hold the number of filled receive slots.
- R6: Control (address 0) bit 1 requests a transmit flush and bit 0 requests a receive flush; writing 0 to these bits has no effect. The queue, including any partly used or partly packed word, is empty after the second clock edge following the write. The bit reads 1 until the third edge and reads 0 after it.
- R7: Control bits [7:5] hold transmit trigger T; `tx_req` is 1 exactly when free transmit slots are at least 8 minus T.
- R8: Control bits [4:2] hold receive trigger R; `rx_req` is 1 exactly when filled receive slots are at least R plus 1.
- R9: A write to address 2 when the transmit queue is full is dropped, and `tx_overflow` is 1 for the single cycle after it.
- R10: A read of address 3 when the receive queue is empty returns 0, and `rx_underflow` is 1 for the single cycle after it.
- R11: `ser_tx_valid` is 0 when the transmit queue is empty, and `ser_rx_ready` is 0 when the receive queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 3) |
| bus_addr | input | 2 | 0 control, 1 status, 2 transmit data, 3 receive data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tx_req | output | 1 | Transmit space request level |
| rx_req | output | 1 | Receive data request level |
| tx_overflow | output | 1 | One-cycle flag: dropped transmit write |
| rx_underflow | output | 1 | One-cycle flag: read of empty receive queue |
| ser_tx_byte | output | 8 | Transmit byte offered to the serial engine |
| ser_tx_valid | output | 1 | Transmit byte available |
| ser_tx_ready | input | 1 | Serial engine takes the offered byte |
| ser_tx_last | input | 1 | Taken byte is the last one used from its word |
| ser_rx_byte | input | 8 | Received byte |
| ser_rx_valid | input | 1 | Received byte present |
| ser_rx_last | input | 1 | Received byte ends the current word |
| ser_rx_ready | output | 1 | Receive byte can be accepted |

## Verification
Damage to a read or write pointer shows as a misordered word, so the sweeps fill and drain each queue through the full depth many times. The first wrap then exposes a bad pointer on the next serial byte or bus read. A wrong occupancy count appears in the status nibbles and in the request levels on the same cycle, and those are compared against arithmetic expectations at every fill level for every trigger value. A stale byte-lane index after a flush or a last flag surfaces on the very next serial byte. A flush that lands a cycle early or late is caught by probing control and status on each of the two cycles after the request.

// File: rtl/wfp_pkg.sv
package wfp_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LANE_W-1:0] lane_t;

    // register addresses on the bus side
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_TXD  = 2'd2,
        REG_RXD  = 2'd3
    } reg_sel_e;

    // one bit per queue for flush bookkeeping
    typedef struct packed {
        logic tx;
        logic rx;
    } flush_t;

    function automatic byte_t lane_of(input word_t w, input lane_t l);
        return w[l*BYTE_W +: BYTE_W];
    endfunction

    function automatic word_t lane_put(input word_t acc, input byte_t b, input lane_t l);
        word_t r;
        r = acc;
        r[l*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

endpackage

// File: rtl/wfp_fifo.sv
module wfp_fifo
    import wfp_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  word_t            wdata,
    input  logic             pop,
    output word_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clr) |=> (count == $past(count))); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R11

endmodule

// File: rtl/wfp_tx_unpack.sv
module wfp_tx_unpack
    import wfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  word_t head,
    input  logic  avail,
    input  logic  take,
    input  logic  last,
    output byte_t byte_out,
    output logic  valid,
    output logic  pop
);

    lane_t lane;

    assign valid    = avail;
    assign byte_out = lane_of(head, lane);
    assign pop      = valid && take && (last || lane == lane_t'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane <= '0;
        end else if (valid && take) begin
            lane <= pop ? '0 : lane + 1'b1;
        end
    end

    AST_TX_LANE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (pop && !clr) |=> (byte_out == lane_of(head, '0))); // R3

endmodule

// File: rtl/wfp_rx_pack.sv
module wfp_rx_pack
    import wfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  in_valid,
    input  byte_t in_byte,
    input  logic  in_last,
    input  logic  room,
    output logic  ready,
    output logic  push,
    output word_t word
);

    lane_t lane;
    word_t acc;
    word_t merged;

    assign ready  = room;
    assign merged = lane_put(acc, in_byte, lane);
    assign push   = in_valid && ready && (in_last || lane == lane_t'(LANES - 1));
    assign word   = merged;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane <= '0;
            acc  <= '0;
        end else if (in_valid && ready) begin
            if (push) begin
                lane <= '0;
                acc  <= '0;
            end else begin
                lane <= lane + 1'b1;
                acc  <= merged;
            end
        end
    end

endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair
    import wfp_pkg::*;
#(
    parameter  int DEPTH       = 8,
    localparam int CNT_W       = $clog2(DEPTH + 1),
    localparam int TRIG_W      = $clog2(DEPTH),
    localparam int RX_TRIG_LSB = 2,
    localparam int TX_TRIG_LSB = RX_TRIG_LSB + TRIG_W
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_req,
    output logic        rx_req,
    output logic        tx_overflow,
    output logic        rx_underflow,
    output logic [7:0]  ser_tx_byte,
    output logic        ser_tx_valid,
    input  logic        ser_tx_ready,
    input  logic        ser_tx_last,
    input  logic [7:0]  ser_rx_byte,
    input  logic        ser_rx_valid,
    input  logic        ser_rx_last,
    output logic        ser_rx_ready
);

    reg_sel_e          sel;
    logic              ctrl_wr, txd_wr, rxd_rd;
    flush_t            fl_req, fl_done;
    logic              tx_clr, rx_clr;
    logic [TRIG_W-1:0] tx_trig, rx_trig;

    word_t             tx_head, rx_head, rx_word;
    logic [CNT_W-1:0]  tx_cnt, rx_cnt, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, rx_push;

    assign sel     = reg_sel_e'(bus_addr);
    assign ctrl_wr = bus_wr && (sel == REG_CTRL);
    assign txd_wr  = bus_wr && (sel == REG_TXD);
    assign rxd_rd  = bus_rd && (sel == REG_RXD);

    // flush: clear on the edge after the request, drop the bit one edge later
    assign tx_clr = fl_req.tx && !fl_done.tx;
    assign rx_clr = fl_req.rx && !fl_done.rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_req       <= '0;
            fl_done      <= '0;
            tx_trig      <= '0;
            rx_trig      <= '0;
            tx_overflow  <= 1'b0;
            rx_underflow <= 1'b0;
        end else begin
            fl_done.tx <= tx_clr;
            fl_done.rx <= rx_clr;
            fl_req.tx  <= (ctrl_wr && bus_wdata[1]) ? 1'b1 : (fl_done.tx ? 1'b0 : fl_req.tx);
            fl_req.rx  <= (ctrl_wr && bus_wdata[0]) ? 1'b1 : (fl_done.rx ? 1'b0 : fl_req.rx);
            if (ctrl_wr) begin
                tx_trig <= bus_wdata[TX_TRIG_LSB +: TRIG_W];
                rx_trig <= bus_wdata[RX_TRIG_LSB +: TRIG_W];
            end
            tx_overflow  <= txd_wr && tx_full;
            rx_underflow <= rxd_rd && rx_empty;
        end
    end

    wfp_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .push(txd_wr), .wdata(bus_wdata), .pop(tx_pop),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    wfp_tx_unpack u_unpack (
        .clk(clk), .rst(rst), .clr(tx_clr),
        .head(tx_head), .avail(!tx_empty),
        .take(ser_tx_ready), .last(ser_tx_last),
        .byte_out(ser_tx_byte), .valid(ser_tx_valid), .pop(tx_pop)
    );

    wfp_rx_pack u_pack (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .in_valid(ser_rx_valid), .in_byte(ser_rx_byte), .in_last(ser_rx_last),
        .room(!rx_full), .ready(ser_rx_ready), .push(rx_push), .word(rx_word)
    );

    wfp_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_clr),
        .push(rx_push), .wdata(rx_word), .pop(rxd_rd),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign tx_free = CNT_W'(DEPTH) - tx_cnt;
    assign tx_req  = tx_free >= (CNT_W'(DEPTH) - CNT_W'(tx_trig));
    assign rx_req  = rx_cnt >= (CNT_W'(rx_trig) + CNT_W'(1));

    always_comb begin
        case (sel)
            REG_CTRL: bus_rdata = WORD_W'({tx_trig, rx_trig, fl_req.tx, fl_req.rx});
            REG_STAT: bus_rdata = WORD_W'({tx_free, rx_cnt});
            REG_RXD:  bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = '0;
        endcase
    end

    AST_FLUSH_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (fl_done.tx && !(ctrl_wr && bus_wdata[1])) |=> !fl_req.tx); // R6
    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rxd_rd && rx_empty) |-> (bus_rdata == '0)); // R10
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
        rx_underflow |-> $past(rx_cnt == '0)); // R10

endmodule

// File: tb/word_fifo_pair_bench.sv
module word_fifo_pair_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_req, rx_req, tx_overflow, rx_underflow;
    logic [7:0]  ser_tx_byte;
    logic        ser_tx_valid;
    logic        ser_tx_ready = 1'b0, ser_tx_last = 1'b0;
    logic [7:0]  ser_rx_byte = '0;
    logic        ser_rx_valid = 1'b0, ser_rx_last = 1'b0;
    logic        ser_rx_ready;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    word_fifo_pair u_word_fifo_pair (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_req(tx_req), .rx_req(rx_req),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow),
        .ser_tx_byte(ser_tx_byte), .ser_tx_valid(ser_tx_valid),
        .ser_tx_ready(ser_tx_ready), .ser_tx_last(ser_tx_last),
        .ser_rx_byte(ser_rx_byte), .ser_rx_valid(ser_rx_valid),
        .ser_rx_last(ser_rx_last), .ser_rx_ready(ser_rx_ready)
    );

    function automatic logic [7:0] bval(input int n, input int j);
        return 8'(16 * n + j + 1);
    endfunction

    function automatic logic [31:0] wval(input int n);
        return {bval(n, 3), bval(n, 2), bval(n, 1), bval(n, 0)};
    endfunction

    task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tx_take(input logic lst, output logic [7:0] b, output logic v);
        #1 b = ser_tx_byte; v = ser_tx_valid;
        ser_tx_ready = 1'b1; ser_tx_last = lst;
        @(negedge clk);
        ser_tx_ready = 1'b0; ser_tx_last = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic lst);
        ser_rx_byte = b; ser_rx_valid = 1'b1; ser_rx_last = lst;
        @(negedge clk);
        ser_rx_valid = 1'b0; ser_rx_last = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  b;
        logic        v;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(2'd1, d); eq("R1 status", d, 32'h80);
        peek(2'd0, d); eq("R1 control", d, 32'h0);
        eq("R1 tx_req", 32'(tx_req), 32'd1);
        eq("R1 rx_req", 32'(rx_req), 32'd0);
        eq("R1 ser_tx_valid", 32'(ser_tx_valid), 32'd0);
        eq("R1 ser_rx_ready", 32'(ser_rx_ready), 32'd1);

        // R7 / R5 / R9: every TX trigger at every fill level
        for (int t = 0; t < 8; t++) begin
            wr(2'd0, 32'((t << 5) | 2));
            @(negedge clk); @(negedge clk);
            for (int n = 0; n <= 8; n++) begin
                eq("R7 tx_req", 32'(tx_req), 32'(n <= t));
                peek(2'd1, d); eq("R5 tx free", 32'(d[7:4]), 32'(8 - n));
                if (n < 8) wr(2'd2, wval(n));
            end
            wr(2'd2, 32'hDEADBEEF);
            eq("R9 tx_overflow pulse", 32'(tx_overflow), 32'd1);
            @(negedge clk);
            eq("R9 tx_overflow single", 32'(tx_overflow), 32'd0);
            peek(2'd1, d); eq("R9 still full", 32'(d[7:4]), 32'd0);
        end

        // R2: drain the full TX queue byte by byte (DEADBEEF must never appear)
        for (int n = 0; n < 8; n++) begin
            for (int j = 0; j < 4; j++) begin
                tx_take(1'b0, b, v);
                eq("R2 tx valid", 32'(v), 32'd1);
                eq("R2 tx byte", 32'(b), 32'(bval(n, j)));
            end
        end
        #1 eq("R11 tx valid when empty", 32'(ser_tx_valid), 32'd0);
        peek(2'd1, d); eq("R5 tx free after drain", 32'(d[7:4]), 32'd8);

        // R3: short word retired by last
        wr(2'd2, wval(8));
        wr(2'd2, wval(9));
        tx_take(1'b0, b, v); eq("R3 byte0", 32'(b), 32'(bval(8, 0)));
        tx_take(1'b1, b, v); eq("R3 byte1 last", 32'(b), 32'(bval(8, 1)));
        tx_take(1'b0, b, v); eq("R3 next word start", 32'(b), 32'(bval(9, 0)));

        // R6: TX flush timing with a partly used word
        wr(2'd0, 32'h2);
        peek(2'd0, d); eq("R6 tx flush bit edge1", 32'(d[1]), 32'd1);
        peek(2'd1, d); eq("R6 tx not yet empty", 32'(d[7:4]), 32'd7);
        @(negedge clk);
        peek(2'd0, d); eq("R6 tx flush bit edge2", 32'(d[1]), 32'd1);
        peek(2'd1, d); eq("R6 tx emptied", 32'(d[7:4]), 32'd8);
        eq("R6 tx valid after flush", 32'(ser_tx_valid), 32'd0);
        @(negedge clk);
        peek(2'd0, d); eq("R6 tx flush bit cleared", 32'(d[1]), 32'd0);
        wr(2'd0, 32'h0);
        peek(2'd0, d); eq("R6 zero write no flush", 32'(d[1:0]), 32'd0);
        wr(2'd2, wval(10));
        tx_take(1'b0, b, v); eq("R6 lane restarts after flush", 32'(b), 32'(bval(10, 0)));
        tx_take(1'b1, b, v);

        // R8 / R5 / R11 / R4: every RX trigger at every fill level
        for (int r = 0; r < 8; r++) begin
            wr(2'd0, 32'((r << 2) | 1));
            @(negedge clk); @(negedge clk);
            for (int n = 0; n <= 8; n++) begin
                eq("R8 rx_req", 32'(rx_req), 32'(n >= r + 1));
                peek(2'd1, d); eq("R5 rx fill", 32'(d[3:0]), 32'(n));
                if (n < 8) begin
                    for (int j = 0; j < 4; j++) rx_send(bval(n, j), 1'b0);
                end
            end
            #1 eq("R11 rx ready when full", 32'(ser_rx_ready), 32'd0);
        end
        for (int n = 0; n < 8; n++) begin
            rd(2'd3, d); eq("R4 rx word", d, wval(n));
        end
        #1 eq("R11 rx ready after drain", 32'(ser_rx_ready), 32'd1);

        // R10 underflow
        rd(2'd3, d); eq("R10 empty read data", d, 32'h0);
        eq("R10 rx_underflow pulse", 32'(rx_underflow), 32'd1);
        @(negedge clk);
        eq("R10 rx_underflow single", 32'(rx_underflow), 32'd0);

        // R4 short word closed by last
        rx_send(8'h5A, 1'b0);
        rx_send(8'hC3, 1'b1);
        rd(2'd3, d); eq("R4 short rx word", d, 32'h0000C35A);

        // R6 RX flush discards a partly packed word
        rx_send(8'h11, 1'b0);
        wr(2'd0, 32'h1);
        peek(2'd0, d); eq("R6 rx flush bit set", 32'(d[0]), 32'd1);
        @(negedge clk); @(negedge clk);
        peek(2'd0, d); eq("R6 rx flush bit cleared", 32'(d[0]), 32'd0);
        for (int j = 0; j < 4; j++) rx_send(8'(8'h21 + j), 1'b0);
        rd(2'd3, d); eq("R6 rx packing restarted", d, 32'h24232221);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule